// File: doc/BRIEF.md
# Transfer Link Steering Predictor

In a clustered out-of-order core, values moving between clusters can travel on one of two links: a fast link built for low delay, or a slower link built for low switching power whose latency is twice that of the fast one. This block makes that choice for each transfer. It returns a registered link select, together with a valid flag and the transfer's tag echoed back, one clock after the request.

Only bypassed register values, which are forwarded from a producer to a waiting consumer, use a learned prediction. A table of small saturating counters, indexed by low-order bits of the producing instruction's address, records whether such values have recently been needed at once. When a consumer issues, the block subtracts the operand's arrival stamp from the issue stamp. It compares that slack against a programmable threshold and moves the counter toward critical or toward non-critical.

Every other transfer class follows a fixed rule. Operands that are already ready, store data, and address transfers that only confirm a trusted address prediction take the power-saving link. Load data and addresses that were not predicted take the fast link.

Top module: `xfer_link_steer`

## Requirements
- R1: The table entry for an address is selected by bits `[PC_LSB +: IDX_W]` of the address (defaults: bits 7:2, 64 entries). Two addresses that agree in these bits share one entry, whatever their other bits.
- R2: While `rst_ni` is low, `out_valid_o` is 0. After reset every entry holds the weakly critical value (binary 10 for 2-bit counters), so a bypass lookup to any untrained address selects the fast link.
- R3: For a request accepted at a rising edge, `out_valid_o` is 1 and `out_tag_o` equals the request tag after that edge. An edge with no request leaves `out_valid_o` at 0.
- R4: For kind 0 (bypassed register value), `out_slow_o` is 0 (fast link) when the indexed counter's top bit is 1, and 1 (power-saving link) when that bit is 0.
- R5: When `upd_valid_i` is high, slack is `upd_issue_i - upd_arrive_i`. A negative slack, or a slack below `thresh_i`, counts as critical and increments the counter, saturating at its maximum. A slack greater than or equal to `thresh_i` decrements the counter, saturating at 0. When `upd_valid_i` is low, the table does not change.
- R6: A positive slack above 32767 (the signed 16-bit maximum) is clamped to 32767 before it is compared with `thresh_i`.
- R7: Kinds 1 (operand ready at dispatch), 2 (store data) and 4 (verification of a high-confidence address prediction) always give `out_slow_o` = 1, whatever the table holds.
- R8: Kinds 3 (load data) and 5 (unpredicted address), and the unassigned kinds 6 and 7, always give `out_slow_o` = 0, whatever the table holds.
- R9: When a lookup and an update address the same entry at the same edge, the lookup result uses the counter value from before that update. The update is visible to lookups at the following edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| thresh_i | input | STAMP_W | Slack threshold in cycles |
| req_valid_i | input | 1 | Steering request present |
| req_kind_i | input | 3 | Transfer class code |
| req_pc_i | input | PC_W | Address of the producing instruction |
| req_tag_i | input | TAG_W | Transfer tag, echoed with the result |
| upd_valid_i | input | 1 | Consumer issue observation present |
| upd_pc_i | input | PC_W | Address of the producer being trained |
| upd_arrive_i | input | STAMP_W | Cycle stamp when the operand reached the consumer cluster |
| upd_issue_i | input | STAMP_W | Cycle stamp when the consumer issued |
| out_valid_o | output | 1 | Steering result present |
| out_slow_o | output | 1 | 1 = power-saving link, 0 = fast link |
| out_tag_o | output | TAG_W | Tag of the steered transfer |

## Verification
A steering result is due one clock after its request. An update changes its counter at the edge where it is presented, so only lookups accepted at a later edge see the change. The bench drives every input on the falling edge and reads the outputs on the next falling edge, halfway after the single register stage. When a check depends on training, the bench places the update at least one edge before the lookup. The one exception is the same-edge collision case, where the bench drives the lookup and the update together on purpose.

// File: rtl/steer_pkg.sv
package steer_pkg;

   typedef enum logic [2:0] {
      XK_BYPASS    = 3'd0,
      XK_READY_OPD = 3'd1,
      XK_STORE_DAT = 3'd2,
      XK_LOAD_DAT  = 3'd3,
      XK_ADDR_CONF = 3'd4,
      XK_ADDR_RAW  = 3'd5
   } xfer_kind_e;

   localparam int KIND_W = 3;

   typedef enum logic {
      LINK_FAST = 1'b0,
      LINK_SLOW = 1'b1
   } link_e;

endpackage

// File: rtl/steer_slack_calc.sv
module steer_slack_calc #(
   parameter int STAMP_W = 16
) (
   input  logic [STAMP_W-1:0] arrive_i,
   input  logic [STAMP_W-1:0] issue_i,
   input  logic [STAMP_W-1:0] thresh_i,
   output logic               crit_o
);
   localparam int DIFF_W = STAMP_W + 1;
   localparam logic [STAMP_W-1:0] SAT_MAX = {1'b0, {(STAMP_W-1){1'b1}}};

   logic signed [DIFF_W-1:0] diff;
   logic                     neg;
   logic                     ovf;
   logic [STAMP_W-1:0]       slack_sat;

   always_comb begin
      diff      = $signed({1'b0, issue_i}) - $signed({1'b0, arrive_i});
      neg       = diff[DIFF_W-1];
      ovf       = !neg && diff[STAMP_W-1];
      if (neg)
         slack_sat = '0;
      else if (ovf)
         slack_sat = SAT_MAX;
      else
         slack_sat = diff[STAMP_W-1:0];
      crit_o    = neg || (slack_sat < thresh_i);
   end

endmodule

// File: rtl/steer_ctr_table.sv
module steer_ctr_table #(
   parameter int IDX_W = 6,
   parameter int CTR_W = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [IDX_W-1:0] rd_idx_i,
   output logic             rd_crit_o,
   input  logic             wr_en_i,
   input  logic [IDX_W-1:0] wr_idx_i,
   input  logic             wr_crit_i
);
   localparam int               ENTRIES = 1 << IDX_W;
   localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};
   localparam logic [CTR_W-1:0] CTR_RST = {1'b1, {(CTR_W-1){1'b0}}};

   logic [ENTRIES-1:0] top_bit;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      logic [CTR_W-1:0] ctr_q;
      logic             hit;

      assign hit = wr_en_i && (wr_idx_i == IDX_W'(g));

      always_ff @(posedge clk_i) begin
         if (!rst_ni)
            ctr_q <= CTR_RST;
         else if (hit) begin
            if (wr_crit_i && (ctr_q != CTR_MAX))
               ctr_q <= ctr_q + 1'b1;
            else if (!wr_crit_i && (ctr_q != '0))
               ctr_q <= ctr_q - 1'b1;
         end
      end

      assign top_bit[g] = ctr_q[CTR_W-1];
   end

   // read returns the stored value; a same-edge write lands afterwards
   assign rd_crit_o = top_bit[rd_idx_i];

endmodule

// File: rtl/steer_link_sel.sv
module steer_link_sel
   import steer_pkg::*;
(
   input  logic [KIND_W-1:0] kind_i,
   input  logic              pred_crit_i,
   output logic              slow_o
);
   always_comb begin
      case (kind_i)
         XK_BYPASS:    slow_o = pred_crit_i ? LINK_FAST : LINK_SLOW;
         XK_READY_OPD: slow_o = LINK_SLOW;
         XK_STORE_DAT: slow_o = LINK_SLOW;
         XK_ADDR_CONF: slow_o = LINK_SLOW;
         XK_LOAD_DAT:  slow_o = LINK_FAST;
         XK_ADDR_RAW:  slow_o = LINK_FAST;
         default:      slow_o = LINK_FAST;
      endcase
   end

endmodule

// File: rtl/xfer_link_steer.sv
module xfer_link_steer
   import steer_pkg::*;
#(
   parameter int PC_W    = 32,
   parameter int PC_LSB  = 2,
   parameter int IDX_W   = 6,
   parameter int CTR_W   = 2,
   parameter int STAMP_W = 16,
   parameter int TAG_W   = 8
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [STAMP_W-1:0] thresh_i,
   input  logic               req_valid_i,
   input  logic [2:0]         req_kind_i,
   input  logic [PC_W-1:0]    req_pc_i,
   input  logic [TAG_W-1:0]   req_tag_i,
   input  logic               upd_valid_i,
   input  logic [PC_W-1:0]    upd_pc_i,
   input  logic [STAMP_W-1:0] upd_arrive_i,
   input  logic [STAMP_W-1:0] upd_issue_i,
   output logic               out_valid_o,
   output logic               out_slow_o,
   output logic [TAG_W-1:0]   out_tag_o
);
   if (PC_LSB + IDX_W > PC_W) begin : g_bad_idx
      $error("index field does not fit in the address");
   end
   if (IDX_W < 1 || IDX_W > 12) begin : g_bad_depth
      $error("IDX_W out of supported range");
   end
   if (CTR_W < 2) begin : g_bad_ctr
      $error("counter needs at least two bits");
   end
   if (STAMP_W < 4) begin : g_bad_stamp
      $error("stamp width too small");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("tag width must be positive");
   end

   logic [IDX_W-1:0] rd_idx;
   logic [IDX_W-1:0] wr_idx;
   logic             pred_crit;
   logic             obs_crit;
   logic             link_slow;
   logic             unused_pc_bits;

   assign rd_idx = req_pc_i[PC_LSB +: IDX_W];
   assign wr_idx = upd_pc_i[PC_LSB +: IDX_W];
   assign unused_pc_bits = ^{req_pc_i, upd_pc_i};

   steer_slack_calc #(
      .STAMP_W (STAMP_W)
   ) u_slack (
      .arrive_i (upd_arrive_i),
      .issue_i  (upd_issue_i),
      .thresh_i (thresh_i),
      .crit_o   (obs_crit)
   );

   steer_ctr_table #(
      .IDX_W (IDX_W),
      .CTR_W (CTR_W)
   ) u_table (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rd_idx_i  (rd_idx),
      .rd_crit_o (pred_crit),
      .wr_en_i   (upd_valid_i),
      .wr_idx_i  (wr_idx),
      .wr_crit_i (obs_crit)
   );

   steer_link_sel u_sel (
      .kind_i      (req_kind_i),
      .pred_crit_i (pred_crit),
      .slow_o      (link_slow)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         out_valid_o <= 1'b0;
         out_slow_o  <= 1'b0;
         out_tag_o   <= '0;
      end else begin
         out_valid_o <= req_valid_i;
         out_slow_o  <= link_slow;
         out_tag_o   <= req_tag_i;
      end
   end

endmodule

// File: rtl/steer_chk.sv
module steer_chk #(
   parameter int TAG_W = 8
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             req_valid_i,
   input logic [2:0]       req_kind_i,
   input logic [TAG_W-1:0] req_tag_i,
   input logic             out_valid_o,
   input logic             out_slow_o,
   input logic [TAG_W-1:0] out_tag_o
);
   // R3
   valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_i |=> out_valid_o);
   // R3
   idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_valid_i |=> !out_valid_o);
   // R3
   tag_echo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_i |=> (out_tag_o == $past(req_tag_i)));
   // R7
   ready_slow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_kind_i == 3'd1) |=> out_slow_o);
   // R7
   store_slow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_kind_i == 3'd2) |=> out_slow_o);
   // R7
   addr_conf_slow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_kind_i == 3'd4) |=> out_slow_o);
   // R8
   load_fast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_kind_i == 3'd3) |=> !out_slow_o);
   // R8
   addr_raw_fast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && (req_kind_i == 3'd5 || req_kind_i[2:1] == 2'b11)) |=> !out_slow_o);

endmodule

bind xfer_link_steer steer_chk #(.TAG_W(TAG_W)) u_steer_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .req_valid_i (req_valid_i),
   .req_kind_i  (req_kind_i),
   .req_tag_i   (req_tag_i),
   .out_valid_o (out_valid_o),
   .out_slow_o  (out_slow_o),
   .out_tag_o   (out_tag_o)
);

// File: tb/xfer_link_steer_tb_top.sv
module xfer_link_steer_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int TAG_W      = 8;
   localparam int WD_LIMIT   = 5000;

   localparam logic [31:0] PC_A     = 32'h40;   // index 16
   localparam logic [31:0] PC_ALIAS = 32'h140;  // index 16
   localparam logic [31:0] PC_NEXT  = 32'h44;   // index 17
   localparam logic [31:0] PC_B     = 32'h80;   // index 32
   localparam logic [31:0] PC_C     = 32'hC0;   // index 48

   // {kind[2:0], use PC_NEXT (else PC_A), expected slow}
   localparam logic [4:0] FIX_VEC [7] = '{
      {3'd1, 1'b1, 1'b1},
      {3'd2, 1'b1, 1'b1},
      {3'd4, 1'b1, 1'b1},
      {3'd3, 1'b0, 1'b0},
      {3'd5, 1'b0, 1'b0},
      {3'd6, 1'b0, 1'b0},
      {3'd7, 1'b0, 1'b0}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [15:0]       thresh = 16'd10;
   logic              req_valid = 1'b0;
   logic [2:0]        req_kind = '0;
   logic [31:0]       req_pc = '0;
   logic [TAG_W-1:0]  req_tag = '0;
   logic              upd_valid = 1'b0;
   logic [31:0]       upd_pc = '0;
   logic [15:0]       upd_arrive = '0;
   logic [15:0]       upd_issue = '0;
   logic              out_valid;
   logic              out_slow;
   logic [TAG_W-1:0]  out_tag;

   int n_chk  = 0;
   int n_fail = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xfer_link_steer dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .thresh_i     (thresh),
      .req_valid_i  (req_valid),
      .req_kind_i   (req_kind),
      .req_pc_i     (req_pc),
      .req_tag_i    (req_tag),
      .upd_valid_i  (upd_valid),
      .upd_pc_i     (upd_pc),
      .upd_arrive_i (upd_arrive),
      .upd_issue_i  (upd_issue),
      .out_valid_o  (out_valid),
      .out_slow_o   (out_slow),
      .out_tag_o    (out_tag)
   );

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   endtask

   task automatic lookup(logic [2:0] kind, logic [31:0] pc, logic [TAG_W-1:0] tag,
                         logic exp_slow, string req);
      @(negedge clk);
      req_valid = 1'b1; req_kind = kind; req_pc = pc; req_tag = tag;
      @(negedge clk);
      check("R3", "valid", {31'd0, out_valid}, 32'd1);
      check("R3", "tag", {24'd0, out_tag}, {24'd0, tag});
      check(req, "slow", {31'd0, out_slow}, {31'd0, exp_slow});
      req_valid = 1'b0;
   endtask

   task automatic train(logic [31:0] pc, logic [15:0] arr, logic [15:0] iss);
      @(negedge clk);
      upd_valid = 1'b1; upd_pc = pc; upd_arrive = arr; upd_issue = iss;
      @(negedge clk);
      upd_valid = 1'b0;
   endtask

   initial begin
      while (1) begin
         @(posedge clk);
         cycles++;
         if (cycles > WD_LIMIT) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WD_LIMIT);
            summary();
         end
      end
   end

   initial begin
      // R2: reset state
      repeat (3) @(negedge clk);
      req_valid = 1'b1; req_kind = 3'd3; req_tag = 8'h11;
      @(negedge clk);
      check("R2", "valid in reset", {31'd0, out_valid}, 32'd0);
      req_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check("R3", "idle valid", {31'd0, out_valid}, 32'd0);

      // R2 R4: untrained entry is weakly critical -> fast
      lookup(3'd0, PC_A, 8'h01, 1'b0, "R2");

      // R5 R4: one non-critical observation (slack 50) -> 01 -> slow
      train(PC_A, 16'd100, 16'd150);
      lookup(3'd0, PC_A, 8'h02, 1'b1, "R4");

      // R1: alias shares entry, neighbour index does not
      lookup(3'd0, PC_ALIAS, 8'h03, 1'b1, "R1");
      lookup(3'd0, PC_NEXT, 8'h04, 1'b0, "R1");

      // R7 R8: fixed classes ignore the table
      for (int i = 0; i < 7; i++) begin
         lookup(FIX_VEC[i][4:2], FIX_VEC[i][1] ? PC_NEXT : PC_A, TAG_W'(8'h20 + i),
                FIX_VEC[i][0], FIX_VEC[i][0] ? "R7" : "R8");
      end

      // R5: update with valid low has no effect
      @(negedge clk);
      upd_valid = 1'b0; upd_pc = PC_NEXT; upd_arrive = 16'd0; upd_issue = 16'd500;
      @(negedge clk);
      lookup(3'd0, PC_NEXT, 8'h30, 1'b0, "R5");

      // R5: negative slack is critical -> 10 -> fast
      train(PC_A, 16'd100, 16'd90);
      lookup(3'd0, PC_A, 8'h31, 1'b0, "R5");

      // R5: slack equal to threshold is non-critical -> 01 slow
      train(PC_A, 16'd100, 16'd110);
      lookup(3'd0, PC_A, 8'h32, 1'b1, "R5");
      // slack just below -> 10 fast
      train(PC_A, 16'd100, 16'd109);
      lookup(3'd0, PC_A, 8'h33, 1'b0, "R5");

      // R5: saturate at top then one non-critical stays fast
      train(PC_A, 16'd5, 16'd5);
      train(PC_A, 16'd5, 16'd5);
      train(PC_A, 16'd5, 16'd5);
      train(PC_A, 16'd5, 16'd100);
      lookup(3'd0, PC_A, 8'h34, 1'b0, "R5");
      train(PC_A, 16'd5, 16'd100);
      lookup(3'd0, PC_A, 8'h35, 1'b1, "R5");

      // R5: saturate at zero, one critical stays slow
      train(PC_A, 16'd5, 16'd100);
      train(PC_A, 16'd5, 16'd100);
      train(PC_A, 16'd5, 16'd5);
      lookup(3'd0, PC_A, 8'h36, 1'b1, "R5");

      // R6: slack 65535 clamps to 32767 < 40000 -> critical -> fast
      thresh = 16'd40000;
      train(PC_B, 16'd0, 16'd65535);
      lookup(3'd0, PC_B, 8'h37, 1'b0, "R6");
      thresh = 16'd10;

      // R9: same-edge lookup and update see the old value
      @(negedge clk);
      req_valid = 1'b1; req_kind = 3'd0; req_pc = PC_C; req_tag = 8'h40;
      upd_valid = 1'b1; upd_pc = PC_C; upd_arrive = 16'd0; upd_issue = 16'd50;
      @(negedge clk);
      check("R9", "slow on collision", {31'd0, out_slow}, 32'd0);
      req_valid = 1'b0; upd_valid = 1'b0;
      lookup(3'd0, PC_C, 8'h41, 1'b1, "R9");

      @(negedge clk);
      check("R3", "idle valid", {31'd0, out_valid}, 32'd0);
      summary();
   end

endmodule